// File: doc/BRIEF.md
# Glitch-Free Clock Select, Divide and Gate Slice

This block builds one output clock from a set of input clocks. A parent selector picks one source, an integer divider divides it, and a gate passes or blocks the result. Software sets all of this through one control register. That register is reached through a simple write port with a per-bit write mask and a combinational read-back.

Selector and divider values written by software are only pending. They reach the clock path only when software sets the commit bit. The slice then runs a safe switchover sequence:

1. Gate the output low.
2. Stop the old source at its low phase.
3. Load the pending values.
4. Start the new source at its low phase.
5. Re-open the gate.
6. Clear the commit bit in hardware.

Software polls that bit to learn when the switch is done. The gate mask is not staged and acts at once, through a glitch-free enable.

The write port accepts a write on every cycle it is asserted. It has no back-pressure and no valid/ready handshake. The clock inputs are free-running and have no flow control.

Top module: `clkmix_slice`

## Requirements
- R1: After reset, the read-back value is 0 and `clk_out` stays low. This means parent 0, divide ratio 1, gate closed and commit bit clear.
- R2: A write changes only the register bits whose `wr_mask` bit is 1. The field layout is:
  - divider field at bits [2:0];
  - parent index at bits [5:4];
  - gate mask at bits [9:8];
  - commit bit at bit 15.

  Read-back returns the written fields and the live commit bit.
- R3: New divider or parent values written without setting the commit bit do not change `clk_out`.
- R4: A write of 1 to the commit bit starts the switchover. The commit bit reads 1 until the switch is done, then clears by itself within 400 register-clock cycles.
- R5: The `clk_out` period equals the selected source period times (divider field + 1), for every field value from 0 to 7.
- R6: For ratio 1, the source passes straight through. For a ratio R above 1, `clk_out` is high for floor(R/2) source periods of each R.
- R7: The parent index selects `src_clk[index]`, and at most one source feeds the divider at any time.
- R8: `clk_out` toggles only when every gate mask bit is 1. With any mask bit 0, `clk_out` holds low.
- R9: No high or low phase of `clk_out` is shorter than half the fastest source period, including during switchover. New settings load only while all sources and the output are gated off.
- R10: A commit with no changed setting still completes and clears within the R4 bound, and the output keeps its previous frequency.
- R11: Writing 0 to the commit bit while a switch is in progress does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_data | input | 16 | Write data |
| wr_mask | input | 16 | Per-bit write enable; bits at 0 keep their value |
| rd_data | output | 16 | Register read-back with live commit bit |
| src_clk | input | 4 | Candidate parent clocks, index 0 to 3 |
| clk_out | output | 1 | Gated, divided output clock |

## Verification
The bench sweeps every parent and every divider value, measuring period and high time against the source period. A wrong ratio encoding would show up as an off-by-one period, and a bad duty cycle as a wrong high time. Pending values are written without a commit, and the output is checked for an unchanged frequency. A design that applied settings at once would shift frequency early. A monitor over the whole run flags any short phase, which is what a switch at an arbitrary phase or a gate opened mid-pulse would produce. Partial gate masks, a commit with nothing changed, and an attempt to clear the commit bit by software are each checked: a single-bit gate decode, a stuck sequencer or a writable commit bit would fail there.

// File: rtl/clkmix_pkg.sv
package clkmix_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_GOFF,
    ST_SOFF,
    ST_APPLY,
    ST_SON,
    ST_GON
  } seq_t;

  localparam int DWELL_W = 2;
  localparam logic [DWELL_W-1:0] DWELL_MIN = 2'd3;
endpackage

// File: rtl/clkmix_gate.sv
module clkmix_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic gclk_in,
  input  logic en_req,
  output logic gclk_out,
  output logic en_ack
);
  logic s1, s2, a1, a2;

  // enable retimed on the falling edge of the gated clock, so it only
  // changes while that clock is low
  always_ff @(negedge gclk_in or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= en_req;
      s2 <= s1;
    end
  end

  assign gclk_out = gclk_in & s2;

  // acknowledge is high while any stage still holds a 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= 1'b0;
      a2 <= 1'b0;
    end else begin
      a1 <= s1 | s2;
      a2 <= a1;
    end
  end

  assign en_ack = a2;
endmodule

// File: rtl/clkmix_div.sv
module clkmix_div #(
  parameter int DIV_W = 3
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] ratio_m1,
  output logic             div_clk
);
  logic [DIV_W-1:0] cnt, nxt;
  logic [DIV_W:0]   half;
  logic             div_q;

  assign half = ({1'b0, ratio_m1} + 1'b1) >> 1;
  assign nxt  = (cnt >= ratio_m1) ? '0 : cnt + 1'b1;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= 1'b0;
    end else begin
      cnt   <= nxt;
      div_q <= ({1'b0, nxt} < half);
    end
  end

  assign div_clk = (ratio_m1 == '0) ? mclk : div_q;
endmodule

// File: rtl/clkmix_ctrl.sv
module clkmix_ctrl
  import clkmix_pkg::*;
#(
  parameter int N_SRC   = 4,
  parameter int SEL_W   = 2,
  parameter int DIV_W   = 3,
  parameter int GATE_W  = 2,
  parameter int REG_W   = 16,
  parameter int DIV_SH  = 0,
  parameter int SEL_SH  = 4,
  parameter int GATE_SH = 8,
  parameter int FC_POS  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_SRC-1:0] src_ack,
  input  logic             out_ack,
  output logic [N_SRC-1:0] src_req,
  output logic             out_req,
  output logic [DIV_W-1:0] act_div
);
  localparam logic [REG_W-1:0] DIV_M  = REG_W'((1 << DIV_W) - 1) << DIV_SH;
  localparam logic [REG_W-1:0] SEL_M  = REG_W'((1 << SEL_W) - 1) << SEL_SH;
  localparam logic [REG_W-1:0] GATE_M = REG_W'((1 << GATE_W) - 1) << GATE_SH;
  localparam logic [REG_W-1:0] FLD_M  = DIV_M | SEL_M | GATE_M;

  seq_t               state, state_d;
  logic [DWELL_W-1:0] dwell;
  logic [REG_W-1:0]   ctrl_q;
  logic               fc_q, fc_set, done, settled, gate_ok;
  logic [SEL_W-1:0]   act_sel, act_sel_d;
  logic [DIV_W-1:0]   act_div_d;
  logic [N_SRC-1:0]   sel_oh, src_req_d;
  logic               sel_ack, sel_ok, out_req_d;

  assign gate_ok = &ctrl_q[GATE_SH +: GATE_W];
  assign fc_set  = wr_en & wr_mask[FC_POS] & wr_data[FC_POS];
  assign settled = (dwell == DWELL_MIN);
  assign rd_data = ctrl_q | (REG_W'(fc_q) << FC_POS);

  always_comb begin
    for (int i = 0; i < N_SRC; i++) sel_oh[i] = (act_sel == SEL_W'(i));
  end
  assign sel_ack = |(src_ack & sel_oh);
  assign sel_ok  = |sel_oh;

  always_comb begin
    state_d = state;
    done    = 1'b0;
    case (state)
      ST_RUN:   if (fc_q) state_d = ST_GOFF;
      ST_GOFF:  if (settled && !out_ack) state_d = ST_SOFF;
      ST_SOFF:  if (settled && src_ack == '0) state_d = ST_APPLY;
      ST_APPLY: state_d = ST_SON;
      ST_SON:   if (settled && (sel_ack || !sel_ok)) state_d = ST_GON;
      ST_GON:   if (settled && out_ack == gate_ok) begin
                  state_d = ST_RUN;
                  done    = 1'b1;
                end
      default:  state_d = ST_RUN;
    endcase
  end

  assign act_sel_d = (state == ST_APPLY) ? ctrl_q[SEL_SH +: SEL_W] : act_sel;
  assign act_div_d = (state == ST_APPLY) ? ctrl_q[DIV_SH +: DIV_W] : act_div;

  always_comb begin
    src_req_d = '0;
    if (state_d == ST_RUN || state_d == ST_GOFF || state_d == ST_SON || state_d == ST_GON)
      for (int i = 0; i < N_SRC; i++) src_req_d[i] = (act_sel_d == SEL_W'(i));
  end
  assign out_req_d = (state_d == ST_RUN || state_d == ST_GON) && gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      dwell   <= '0;
      ctrl_q  <= '0;
      fc_q    <= 1'b0;
      act_sel <= '0;
      act_div <= '0;
      src_req <= '0;
      out_req <= 1'b0;
    end else begin
      state   <= state_d;
      dwell   <= (state_d != state) ? '0 : (settled ? dwell : dwell + 1'b1);
      if (wr_en) ctrl_q <= ((ctrl_q & ~wr_mask) | (wr_data & wr_mask)) & FLD_M;
      if (fc_set) fc_q <= 1'b1;
      else if (done) fc_q <= 1'b0;
      act_sel <= act_sel_d;
      act_div <= act_div_d;
      src_req <= src_req_d;
      out_req <= out_req_d;
    end
  end

  // R4
  fc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> fc_q);
  // R3
  commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_sel, act_div}) |-> $past(state) == ST_APPLY);
  // R9
  apply_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APPLY) |-> (src_ack == '0 && !out_ack));
  // R7
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_req));
  // R11
  fc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fc_q) |-> $past(state) == ST_GON);
endmodule

// File: rtl/clkmix_slice.sv
module clkmix_slice #(
  parameter int N_SRC   = 4,
  parameter int DIV_W   = 3,
  parameter int GATE_W  = 2,
  parameter int REG_W   = 16,
  parameter int DIV_SH  = 0,
  parameter int SEL_SH  = 4,
  parameter int GATE_SH = 8,
  parameter int FC_POS  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] wr_mask,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_SRC-1:0] src_clk,
  output logic             clk_out
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] src_req, src_ack, src_gated;
  logic [DIV_W-1:0] act_div;
  logic             out_req, out_ack, mclk, div_clk;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    clkmix_gate u_src_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .gclk_in  (src_clk[g]),
      .en_req   (src_req[g]),
      .gclk_out (src_gated[g]),
      .en_ack   (src_ack[g])
    );
  end

  assign mclk = |src_gated;

  clkmix_div #(.DIV_W(DIV_W)) u_div (
    .mclk     (mclk),
    .rst_n    (rst_n),
    .ratio_m1 (act_div),
    .div_clk  (div_clk)
  );

  clkmix_gate u_out_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .gclk_in  (div_clk),
    .en_req   (out_req),
    .gclk_out (clk_out),
    .en_ack   (out_ack)
  );

  clkmix_ctrl #(
    .N_SRC(N_SRC), .SEL_W(SEL_W), .DIV_W(DIV_W), .GATE_W(GATE_W), .REG_W(REG_W),
    .DIV_SH(DIV_SH), .SEL_SH(SEL_SH), .GATE_SH(GATE_SH), .FC_POS(FC_POS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_mask (wr_mask),
    .rd_data (rd_data),
    .src_ack (src_ack),
    .out_ack (out_ack),
    .src_req (src_req),
    .out_req (out_req),
    .act_div (act_div)
  );
endmodule

// File: tb/test_clkmix_slice.sv
`timescale 1ns/100ps
module test_clkmix_slice;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0, wr_mask = '0, rd_data;
  logic        s0 = 0, s1 = 0, s2 = 0, s3 = 0, clk_out;
  logic [3:0]  src_clk;
  int          n_chk = 0, n_fail = 0, edges = 0, runts = 0;
  realtime     last_rise = -1.0, last_fall = -1.0;
  real         per_tab [4] = '{10.0, 14.0, 22.0, 34.0};

  assign src_clk = {s3, s2, s1, s0};

  initial begin #0.5; forever #10 clk = ~clk; end
  always #5  s0 = ~s0;
  always #7  s1 = ~s1;
  always #11 s2 = ~s2;
  always #17 s3 = ~s3;

  clkmix_slice i_clkmix_slice (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_data(rd_data), .src_clk(src_clk), .clk_out(clk_out)
  );

  // R9 phase monitor: no phase shorter than 4.9 ns (fastest half period is 5 ns)
  always @(posedge clk_out) begin
    edges++;
    if (last_fall >= 0.0 && ($realtime - last_fall) < 4.9) runts++;
    last_rise = $realtime;
  end
  always @(negedge clk_out) begin
    if (last_rise >= 0.0 && ($realtime - last_rise) < 4.9) runts++;
    last_fall = $realtime;
  end

  task automatic chk_int(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_real(input string req, input real act, input real exp);
    n_chk++;
    if (act - exp > 0.05 || exp - act > 0.05) begin
      n_fail++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic wait_fc(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (rd_data[15] && cyc < 2000);
  endtask

  task automatic measure(output real per, output real hi);
    realtime t0, t1, t2;
    @(posedge clk_out); @(posedge clk_out);
    t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0; hi = t1 - t0;
  endtask

  task automatic check_shape(input string req, input int sel, input int dv);
    real per, hi, ehi;
    int  r = dv + 1;
    measure(per, hi);
    ehi = (r == 1) ? per_tab[sel] / 2.0 : per_tab[sel] * (r / 2);
    chk_real({req, " period"}, per, per_tab[sel] * r);
    chk_real({req, " high"}, hi, ehi);
  endtask

  initial begin
    int cyc, e0;
    #2000;
    begin
      // R1 reset state
      chk_int("R1 readback", rd_data, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk_int("R1 readback after release", rd_data, 0);
      e0 = edges; #3000;
      chk_int("R1 no output edges", edges - e0, 0);
      chk_int("R1 output low", clk_out, 0);

      // R5 R6 R7 R4 full sweep
      for (int sel = 0; sel < 4; sel++) begin
        for (int dv = 0; dv < 8; dv++) begin
          wr(16'h8000 | 16'h0300 | 16'(sel << 4) | 16'(dv), 16'hFFFF);
          wait_fc(cyc);
          chk_int("R4 commit clears in bound", (cyc <= 400) ? 1 : 0, 1);
          check_shape("R5 R6 R7", sel, dv);
        end
      end

      // R2 masked write of parent field only
      wr(16'h0010, 16'h0030);
      chk_int("R2 masked readback", rd_data, 16'h0317);
      // R3 pending value not applied yet
      check_shape("R3 old setting held", 3, 7);
      wr(16'h8000, 16'h8000);
      wait_fc(cyc);
      chk_int("R4 commit clears", rd_data[15], 0);
      check_shape("R3 new setting after commit", 1, 7);

      // R10 commit with nothing changed
      wr(16'h8000, 16'h8000);
      wait_fc(cyc);
      chk_int("R10 no-change commit bound", (cyc <= 400) ? 1 : 0, 1);
      check_shape("R10 frequency kept", 1, 7);

      // R11 software cannot clear commit bit mid-switch
      wr(16'h8002, 16'h8007);
      wr(16'h0000, 16'h8000);
      chk_int("R11 commit still set", rd_data[15], 1);
      wait_fc(cyc);
      chk_int("R11 completes", rd_data[15], 0);
      check_shape("R11 new ratio", 1, 2);

      // R8 partial gate masks hold output low
      for (int gm = 0; gm < 3; gm++) begin
        wr(16'(gm << 8), 16'h0300);
        #1000; e0 = edges; #3000;
        chk_int("R8 partial mask edges", edges - e0, 0);
        chk_int("R8 partial mask level", clk_out, 0);
      end
      wr(16'h0300, 16'h0300);
      check_shape("R8 full mask runs", 1, 2);

      // R9 no short phase during the whole run
      chk_int("R9 short phases", runts, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule